// File: doc/BRIEF.md
# Multi-Profile SPI Master Shifter

This block is the serial engine of an SPI master. Software fills eight 32-bit transfer profiles through a plain write port. Each frame arrives as a command word with a 3-bit profile selector and up to 16 data bits. The selected profile fixes five properties of that one frame: the number of bits, the SCK idle level, the clock phase, the bit order, and the wait between chip-select assertion and the first SCK edge.

A frame is taken only while the engine is idle. The engine copies the selected profile into a private register when it accepts the frame, so a profile written while a frame is running changes only later frames. It drives SCK, MOSI and one active-low chip select, and it samples MISO. At the end of the frame it returns the received word with a one-cycle valid pulse. The SCK half-period is a parameter, 2 system clocks by default.

Top module: `spi_profile_master`

## Requirements
- R1: Profile i is written when `cfg_wr_en` is high with `cfg_wr_sel`=i. A frame uses the profile indexed by its `cmd_sel`. Profile fields by bit position: [30:27] size code, [26] CPOL, [25] CPHA, [24] LSB-first, [23:22] lead prescale code, [15:12] lead exponent. All other bits have no effect.
- R2: After reset, every profile holds size code 15 and zero in every other field. That means 16 bits, CPOL=0, CPHA=0, MSB first and a lead time of 2 clocks. Also after reset `cs_n`=1, `sck`=0, `cmd_ready`=1 and `rx_valid`=0.
- R3: `sck` sits at the CPOL level (0 low, 1 high) when chip select asserts, and it is back at that level when chip select releases.
- R4: With CPHA=0, each bit is on MOSI at the leading SCK edge and is captured there, and MOSI changes on trailing edges. With CPHA=1, MOSI changes on leading edges and bits are captured on trailing edges.
- R5: With LSB-first=0 the data goes out from bit n-1 down to bit 0. With LSB-first=1 it goes out from bit 0 up to bit n-1. The received bits are packed into `rx_data[n-1:0]` in the same order, and the upper bits are zero.
- R6: A frame has n bits and 2n SCK edges. n = size code + 1 for codes 3 to 15. Codes 0 to 2 give n = 4.
- R7: The first SCK edge comes (2p+1)·2^(e+1) clocks after the clock edge at which `cs_n` falls. Here p is the lead prescale code and e is the lead exponent.
- R8: SCK edges are 2 clocks apart. `cs_n` rises 2 clocks after the last SCK edge. `rx_valid` is high for exactly that one cycle, with the received word on `rx_data`.
- R9: `cmd_ready` is high only while idle, and a frame is accepted only then. A profile write during a frame does not change that frame and applies from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Profile write strobe |
| cfg_wr_sel | input | 3 | Profile index to write |
| cfg_wr_data | input | 32 | Profile word |
| cmd_valid | input | 1 | Frame command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_sel | input | 3 | Profile selector for this frame |
| cmd_data | input | 16 | Transmit data, right-justified |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| rx_valid | output | 1 | One-cycle pulse with received word |
| rx_data | output | 16 | Received word, right-justified |

## Verification
The hardest case to reach from the ports is a profile rewritten while a frame that uses it is still shifting. The stimulus starts a frame on profile 0 and writes profile 0 a few clocks after chip select falls. It checks that the running frame keeps its old timing and order, and that the next frame follows the new word. A second hard case is a profile that has never been written, which the stimulus uses before any write. MISO is looped back from MOSI through an optional inverter, so the received word shows corruption that a plain loopback would hide. The bench decodes MOSI on the capture edges it expects, so a fault in bit order or phase shows up even when the round trip still looks correct.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int MAX_BITS = 16;
    localparam int PROF_W   = 32;
    localparam int DLY_W    = 19;                      // 7 * 2^16 fits
    localparam int EDGE_W   = $clog2(2 * MAX_BITS) + 1;
    localparam logic [PROF_W-1:0] PROF_RST = 32'h7800_0000;

    typedef struct packed {
        logic [4:0]       nbits;
        logic             cpol;
        logic             cpha;
        logic             lsb;
        logic [DLY_W-1:0] lead;
    } prof_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL} st_t;

    function automatic prof_t decode(input logic [PROF_W-1:0] w);
        prof_t      p;
        logic [3:0] code;
        logic [2:0] pf;
        code    = w[30:27];
        p.nbits = (code < 4'd3) ? 5'd4 : {1'b0, code} + 5'd1;
        p.cpol  = w[26];
        p.cpha  = w[25];
        p.lsb   = w[24];
        pf      = {w[23:22], 1'b1};                     // 1,3,5,7
        p.lead  = DLY_W'({16'd0, pf} << ({1'b0, w[15:12]} + 5'd1));
        return p;
    endfunction

    function automatic logic [MAX_BITS-1:0] justify(input logic [MAX_BITS-1:0] d,
                                                    input logic [4:0] n,
                                                    input logic lsb);
        return lsb ? d : d << (5'd16 - n);
    endfunction

    function automatic logic head(input logic [MAX_BITS-1:0] sr, input logic lsb);
        return lsb ? sr[0] : sr[MAX_BITS-1];
    endfunction

    function automatic logic [MAX_BITS-1:0] advance(input logic [MAX_BITS-1:0] sr,
                                                    input logic lsb);
        return lsb ? (sr >> 1) : (sr << 1);
    endfunction

endpackage

// File: rtl/spm_attr_bank.sv
module spm_attr_bank
    import spm_pkg::*;
#(
    parameter int N_PROF = 8,
    localparam int SEL_W = $clog2(N_PROF)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [PROF_W-1:0]        wr_data,
    output logic [N_PROF*PROF_W-1:0] bank
);
    // R1/R2: one register per profile, reserved top bit never stored
    for (genvar i = 0; i < N_PROF; i++) begin : g_prof
        logic [PROF_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= PROF_RST;
            else if (wr_en && wr_sel == SEL_W'(i))
                word_q <= {1'b0, wr_data[PROF_W-2:0]};
        end
        assign bank[i*PROF_W +: PROF_W] = word_q;
    end
endmodule

// File: rtl/spm_engine.sv
module spm_engine
    import spm_pkg::*;
#(
    parameter int HALF = 2,
    localparam int HW = $clog2(HALF + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [PROF_W-1:0]   cmd_prof,
    input  logic [MAX_BITS-1:0] cmd_data,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic                cs_n,
    output logic                rx_valid,
    output logic [MAX_BITS-1:0] rx_data
);
    st_t                 st;
    prof_t               p_q;
    logic [DLY_W-1:0]    dly;
    logic [HW-1:0]       hcnt;
    logic [EDGE_W-1:0]   k;
    logic [MAX_BITS-1:0] tx_sr, rx_sr;

    prof_t               p_new;
    logic [MAX_BITS-1:0] aligned;
    logic                ev, leading, cap, last, launch;

    always_comb begin
        p_new   = decode(cmd_prof);
        aligned = justify(cmd_data, p_new.nbits, p_new.lsb);
        ev      = (st == ST_LEAD && dly == '0) || (st == ST_SHIFT && hcnt == '0);
        leading = ~k[0];
        cap     = leading ^ p_q.cpha;                              // R4
        last    = (k == EDGE_W'({p_q.nbits, 1'b0} - 6'd1));        // R6
        launch  = !cap && !(last && !p_q.cpha);
    end

    assign cmd_ready = (st == ST_IDLE);                            // R9

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            p_q      <= '0;
            dly      <= '0;
            hcnt     <= '0;
            k        <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            sck      <= 1'b0;
            mosi     <= 1'b0;
            cs_n     <= 1'b1;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            unique case (st)
                ST_IDLE: if (cmd_valid) begin
                    p_q   <= p_new;                                // R9: profile frozen
                    cs_n  <= 1'b0;
                    sck   <= p_new.cpol;                           // R3
                    dly   <= p_new.lead - DLY_W'(1);               // R7
                    k     <= '0;
                    rx_sr <= '0;
                    if (!p_new.cpha) begin
                        mosi  <= head(aligned, p_new.lsb);
                        tx_sr <= advance(aligned, p_new.lsb);
                    end else begin
                        mosi  <= 1'b0;
                        tx_sr <= aligned;
                    end
                    st <= ST_LEAD;
                end
                ST_LEAD:  if (dly != '0) dly <= dly - DLY_W'(1);
                ST_SHIFT: if (hcnt != '0) hcnt <= hcnt - HW'(1);
                ST_TAIL: begin
                    if (hcnt != '0) begin
                        hcnt <= hcnt - HW'(1);
                    end else begin                                 // R8
                        cs_n     <= 1'b1;
                        rx_valid <= 1'b1;
                        rx_data  <= p_q.lsb ? (rx_sr >> (5'd16 - p_q.nbits)) : rx_sr;
                        mosi     <= 1'b0;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase

            if (ev) begin
                sck  <= ~sck;
                k    <= k + EDGE_W'(1);
                hcnt <= HW'(HALF - 1);
                if (cap)                                           // R5
                    rx_sr <= p_q.lsb ? {miso, rx_sr[MAX_BITS-1:1]}
                                     : {rx_sr[MAX_BITS-2:0], miso};
                if (launch) begin
                    mosi  <= head(tx_sr, p_q.lsb);
                    tx_sr <= advance(tx_sr, p_q.lsb);
                end
                st <= last ? ST_TAIL : ST_SHIFT;
            end
        end
    end

    a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> sck == p_q.cpol);
    a_r7_no_edge_at_select: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |=> $stable(sck));
    a_r8_edge_spacing: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sck) && !cs_n) |=> $stable(sck));
    a_r8_valid_at_release: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $rose(cs_n));
    a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> cs_n);

endmodule

// File: rtl/spi_profile_master.sv
module spi_profile_master
    import spm_pkg::*;
#(
    parameter int N_PROF = 8,
    parameter int HALF   = 2,
    localparam int SEL_W = $clog2(N_PROF)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr_en,
    input  logic [SEL_W-1:0]    cfg_wr_sel,
    input  logic [PROF_W-1:0]   cfg_wr_data,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [SEL_W-1:0]    cmd_sel,
    input  logic [MAX_BITS-1:0] cmd_data,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic                cs_n,
    output logic                rx_valid,
    output logic [MAX_BITS-1:0] rx_data
);
    logic [N_PROF*PROF_W-1:0] bank;
    logic [PROF_W-1:0]        sel_word;

    spm_attr_bank #(.N_PROF(N_PROF)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr_en),
        .wr_sel (cfg_wr_sel),
        .wr_data(cfg_wr_data),
        .bank   (bank)
    );

    assign sel_word = bank[cmd_sel*PROF_W +: PROF_W];   // R1

    spm_engine #(.HALF(HALF)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_prof (sel_word),
        .cmd_data (cmd_data),
        .sck      (sck),
        .mosi     (mosi),
        .miso     (miso),
        .cs_n     (cs_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );
endmodule

// File: tb/tb_spi_profile_master.sv
`timescale 1ns/1ps
module tb_spi_profile_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_sel = '0;
    logic [15:0] cmd_data = '0;
    logic        sck, mosi, miso, cs_n, rx_valid;
    logic [15:0] rx_data;
    logic        flip_r = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;                 // 250 MHz
    assign miso = mosi ^ flip_r;

    spi_profile_master dut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_sel(cmd_sel), .cmd_data(cmd_data), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // {flip, lsb, cpha, cpol, code[3:0], pre[1:0], exp[3:0], data[15:0]}
    localparam logic [29:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd7,  2'd0, 4'd0, 16'h00A5},
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd7,  2'd1, 4'd1, 16'h003C},
        {1'b0, 1'b0, 1'b1, 1'b0, 4'd15, 2'd2, 4'd0, 16'hBEEF},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd11, 2'd3, 4'd2, 16'h05A3},
        {1'b0, 1'b0, 1'b0, 1'b1, 4'd1,  2'd0, 4'd0, 16'h0009},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd3,  2'd0, 4'd1, 16'h000B},
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd4,  2'd1, 4'd0, 16'h0013},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd9,  2'd0, 4'd3, 16'h02C5}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(input logic [3:0] code, input logic cpol,
                                        input logic cpha, input logic lsb,
                                        input logic [1:0] pre, input logic [3:0] ex);
        return {1'b1, code, cpol, cpha, lsb, pre, 6'h2A, ex, 12'hF0F}; // R1: stray bits ignored
    endfunction

    task automatic wr_prof(input logic [2:0] sel, input logic [31:0] w);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = w;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic frame(input logic [2:0] sel, input logic [3:0] code, input logic cpol,
                         input logic cpha, input logic lsb, input logic [1:0] pre,
                         input logic [3:0] ex, input logic [15:0] data, input logic flip,
                         input bit mid, input logic [31:0] mid_w);
        int n, d, t, edges, first_t, last_t, ncap, bitbad, rx_t;
        logic prev;
        logic [15:0] rxv, expv;
        n = (code < 3) ? 4 : code + 1;
        d = (2 * pre + 1) * (1 << (ex + 1));
        expv = (flip ? ~data : data) & 16'((32'd1 << n) - 1);
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R9 ready when idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_sel = sel; cmd_data = data; flip_r = flip;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cs_n === 1'b0, "R9 accepted when idle", cs_n, 0);
        chk(sck === cpol, "R3 sck idle level at select", sck, cpol);
        t = 0; edges = 0; first_t = -1; last_t = -1; ncap = 0; bitbad = 0;
        rx_t = -1; rxv = '0; prev = sck;
        while (!cs_n && t < d + 4 * n + 20) begin
            @(negedge clk);
            t++;
            if (mid && t == 3) begin
                cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = mid_w;
            end else cfg_wr_en = 1'b0;
            if (t == 1) chk(cmd_ready === 1'b0, "R9 busy during frame", cmd_ready, 0);
            if (sck !== prev) begin
                if (edges == 0) first_t = t;
                if ((((edges % 2) == 0) ? 1'b1 : 1'b0) ^ cpha) begin
                    if (mosi !== (lsb ? data[ncap] : data[n - 1 - ncap])) bitbad++;
                    ncap++;
                end
                edges++;
                last_t = t;
                prev = sck;
            end
            if (rx_valid) begin rx_t = t; rxv = rx_data; end
        end
        cfg_wr_en = 1'b0;
        chk(first_t == d, "R7 lead time", first_t, d);
        chk(edges == 2 * n, "R6 edge count", edges, 2 * n);
        chk(bitbad == 0, "R4 R5 mosi bit at capture edge", bitbad, 0);
        chk(cs_n === 1'b1 && t == last_t + 2, "R8 release delay", t - last_t, 2);
        chk(rx_t == t, "R8 rx_valid at release", rx_t, t);
        chk(rxv == expv, "R5 received word", rxv, expv);
        chk(sck === cpol, "R3 sck idle after frame", sck, cpol);
        @(negedge clk);
        chk(rx_valid === 1'b0, "R8 single valid pulse", rx_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state at the ports
        chk(cs_n === 1'b1, "R2 cs_n after reset", cs_n, 1);
        chk(sck === 1'b0, "R2 sck after reset", sck, 0);
        chk(cmd_ready === 1'b1, "R2 ready after reset", cmd_ready, 1);
        chk(rx_valid === 1'b0, "R2 rx_valid after reset", rx_valid, 0);
        // R2: unwritten profile gives 16 bits, mode 0, MSB first, lead 2
        frame(3'd5, 4'd15, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 16'h9C31, 1'b1, 1'b0, '0);

        // R1 R3 R4 R5 R6 R7: table walk, one profile per vector
        for (int i = 0; i < 8; i++) begin
            logic [29:0] v;
            v = VEC[i];
            wr_prof(3'(i), mkw(v[25:22], v[26], v[27], v[28], v[21:20], v[19:16]));
        end
        for (int i = 7; i >= 0; i--) begin
            logic [29:0] v;
            v = VEC[i];
            frame(3'(i), v[25:22], v[26], v[27], v[28], v[21:20], v[19:16],
                  v[15:0], v[29], 1'b0, '0);
        end

        // R9: rewrite profile 0 during its own frame, then use the new one
        frame(3'd0, 4'd7, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 16'h0081, 1'b0,
              1'b1, mkw(4'd5, 1'b1, 1'b1, 1'b1, 2'd0, 4'd1));
        frame(3'd0, 4'd5, 1'b1, 1'b1, 1'b1, 2'd0, 4'd1, 16'h0029, 1'b1, 1'b0, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule